// File: doc/BRIEF.md
# GF(2) Byte Affine Transform Unit

The unit applies an affine map over GF(2) to every byte of a packed data vector. For each byte `x` it computes `y = A·x + b`. Here `A` is an 8x8 bit matrix, `b` is an 8-bit constant, multiplication is bitwise AND and addition is exclusive-OR. The data vector is made of `LANES` 64-bit lanes. A second vector of the same width supplies one 64-bit matrix word per lane. All eight bytes of a lane share that lane's matrix word.

Inside a matrix word, the rows are stored in reverse order: byte `i` of the word defines result bit `7-i`. The constant `b` is a single 8-bit immediate that is added to every byte of the vector.

The result is registered once. A strobe on `in_valid_i` produces `out_valid_o` on the next cycle. The registered result holds its value until the next strobe. Typical uses are bit permutation, bit reversal, sign spreading and other per-byte bit-matrix work.

Top module: `gf2_affine_unit`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first strobe, `out_valid_o` is 0 and `result_o` is all zeros.
- R2: `out_valid_o` is 1 in exactly those cycles that directly follow a cycle in which `in_valid_i` was 1 at the clock edge, giving a latency of one cycle.
- R3: When `in_valid_i` is 0 at a clock edge, `result_o` keeps its previous value, whatever the other inputs do.
- R4: For byte `j` of lane `k`, let `x` be data bits `[64k+8j+7 : 64k+8j]` and let row `i` be matrix bits `[64k+8i+7 : 64k+8i]`. Then result bit `7-i` of that byte is the XOR of all bits of `(row_i AND x)`, XORed with `bconst_i[7-i]`.
- R5: The matrix word `0x0102040810204080` with `b = 0x00` passes each data byte through unchanged.
- R6: The matrix word `0x8040201008040201` with `b = 0x00` reverses the bit order of each byte (bit 0 becomes bit 7).
- R7: The bytes of lane `k` depend only on matrix word `k`. Different matrix words in different lanes give independent results.
- R8: An all-zero matrix word yields `bconst_i` in every byte of its lane. The same constant is added to every byte of every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input strobe; captures the transform of the current inputs |
| data_i | input | 64*LANES | Packed data bytes |
| mat_i | input | 64*LANES | One 64-bit matrix word per lane, rows in reverse order |
| bconst_i | input | 8 | Affine constant added to every byte |
| out_valid_o | output | 1 | High one cycle after a strobe |
| result_o | output | 64*LANES | Registered transformed bytes |

## Verification
Four properties are checked on every cycle:
- the one-cycle strobe latency and the absence of spurious valids;
- the holding of the result between strobes;
- the constant-only output for a zero matrix;
- the pass-through under the identity matrix.

The remaining behaviours can only be shown by the bench scenarios. These are the exact bit placement of the reversed-row matrix encoding under random matrices, bit reversal, lane independence with mixed matrix words, and back-to-back strobes. For these, a reference model computes each expected byte from R4.

// File: rtl/gfa_pkg.sv
package gfa_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned BYTES_PW = WORD_W / BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  // Matrix word that maps every byte onto itself (row i selects bit 7-i).
  function automatic word_t identity_word();
    word_t w;
    w = '0;
    for (int i = 0; i < BYTES_PW; i++) begin
      w[i*BYTE_W + (BYTE_W-1-i)] = 1'b1;
    end
    return w;
  endfunction
endpackage

// File: rtl/gfa_byte_xform.sv
module gfa_byte_xform
  import gfa_pkg::*;
#(
  parameter int unsigned BW = BYTE_W
) (
  input  logic [BW*BW-1:0] rows_i,
  input  logic [BW-1:0]    x_i,
  input  logic [BW-1:0]    b_i,
  output logic [BW-1:0]    y_o
);
  // Row r of the packed word builds result bit BW-1-r.
  for (genvar r = 0; r < BW; r++) begin : g_row
    logic [BW-1:0] masked;
    assign masked         = rows_i[r*BW +: BW] & x_i;
    assign y_o[BW-1-r]    = (^masked) ^ b_i[BW-1-r];
  end
endmodule

// File: rtl/gfa_lane.sv
module gfa_lane
  import gfa_pkg::*;
#(
  parameter int unsigned LANE_W = WORD_W
) (
  input  logic [LANE_W-1:0] data_i,
  input  logic [LANE_W-1:0] mat_i,
  input  logic [BYTE_W-1:0] b_i,
  output logic [LANE_W-1:0] y_o
);
  localparam int unsigned NBYTES = LANE_W / BYTE_W;

  for (genvar j = 0; j < NBYTES; j++) begin : g_byte
    gfa_byte_xform #(.BW(BYTE_W)) i_byte (
      .rows_i (mat_i),
      .x_i    (data_i[j*BYTE_W +: BYTE_W]),
      .b_i    (b_i),
      .y_o    (y_o[j*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/gf2_affine_unit.sv
module gf2_affine_unit
  import gfa_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic [LANES*WORD_W-1:0] data_i,
  input  logic [LANES*WORD_W-1:0] mat_i,
  input  logic [BYTE_W-1:0]       bconst_i,
  output logic                    out_valid_o,
  output logic [LANES*WORD_W-1:0] result_o
);
  localparam int unsigned VEC_W = LANES * WORD_W;
  localparam int unsigned VEC_B = VEC_W / BYTE_W;

  logic [VEC_W-1:0] xform;
  logic [VEC_W-1:0] res_q, res_d;
  logic             vld_q, vld_d;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    gfa_lane #(.LANE_W(WORD_W)) i_lane (
      .data_i (data_i[k*WORD_W +: WORD_W]),
      .mat_i  (mat_i[k*WORD_W +: WORD_W]),
      .b_i    (bconst_i),
      .y_o    (xform[k*WORD_W +: WORD_W])
    );
  end

  // Next-state logic
  always_comb begin
    vld_d = in_valid_i;
    res_d = res_q;
    if (in_valid_i) res_d = xform;
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid_o = vld_q;
  assign result_o    = res_q;

  // Checks
  logic all_ident, all_zero;
  always_comb begin
    all_ident = 1'b1;
    for (int k = 0; k < LANES; k++)
      if (mat_i[k*WORD_W +: WORD_W] != identity_word()) all_ident = 1'b0;
  end
  assign all_zero = (mat_i == '0);

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));
  p_zero_mat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && all_zero) |=> (result_o == {VEC_B{$past(bconst_i)}}));
  p_identity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && all_ident && bconst_i == '0) |=> (result_o == $past(data_i)));
endmodule

// File: tb/test_gf2_affine_unit.sv
module test_gf2_affine_unit;
  localparam int LANES = 2;
  localparam int VW    = LANES * 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] data = '0, mat = '0;
  logic [7:0]    bconst = '0;
  logic          out_valid;
  logic [VW-1:0] result;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [VW-1:0] exp; string tag; } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  gf2_affine_unit #(.LANES(LANES)) i_gf2_affine_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .data_i(data), .mat_i(mat), .bconst_i(bconst),
    .out_valid_o(out_valid), .result_o(result));

  localparam logic [63:0] IDENT = 64'h0102040810204080;
  localparam logic [63:0] REVRS = 64'h8040201008040201;

  // Reference model written from R4: matrix byte i builds result bit 7-i.
  function automatic logic [VW-1:0] ref_model(logic [VW-1:0] d, logic [VW-1:0] m, logic [7:0] b);
    logic [VW-1:0] y;
    for (int k = 0; k < LANES; k++)
      for (int j = 0; j < 8; j++)
        for (int i = 0; i < 8; i++) begin
          logic [7:0] x, row;
          x   = d[k*64 + j*8 +: 8];
          row = m[k*64 + i*8 +: 8];
          y[k*64 + j*8 + (7-i)] = (^(row & x)) ^ b[7-i];
        end
    return y;
  endfunction

  function automatic logic [7:0] rev8(logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: strobe one vector and push its expected value.
  task automatic drive(logic [VW-1:0] d, logic [VW-1:0] m, logic [7:0] b,
                       logic [VW-1:0] exp, string tag);
    item_t it;
    @(negedge clk);
    data = d; mat = m; bconst = b; in_valid = 1'b1;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      data = {$urandom, $urandom, $urandom, $urandom};
      mat  = {$urandom, $urandom, $urandom, $urandom};
      bconst = 8'($urandom);
    end
  endtask

  // Monitor: samples 1 ns after each rising edge.
  logic [VW-1:0] last_res = '0;
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(out_valid === 1'b1, "R2 valid", {{(VW-1){1'b0}}, out_valid}, 1);
        check(result === it.exp, it.tag, result, it.exp);
      end else begin
        check(out_valid === 1'b0, "R2 no valid", {{(VW-1){1'b0}}, out_valid}, 0);
        check(result === last_res, "R3 hold", result, last_res);
      end
      last_res = result;
    end
  end

  initial begin
    logic [VW-1:0] d, m, e;
    // R1: reset state
    data = {4{32'hDEADBEEF}}; mat = {LANES{IDENT}}; in_valid = 1'b1;
    #11;
    check(out_valid === 1'b0, "R1 valid in reset", {{(VW-1){1'b0}}, out_valid}, 0);
    check(result === '0, "R1 result in reset", result, '0);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && result === '0, "R1 after release", result, '0);

    // R5: identity pass-through
    d = {32'h01234567, 32'h89ABCDEF, 32'hF00DFACE, 32'h5A5AA5A5};
    drive(d, {LANES{IDENT}}, 8'h00, d, "R5 identity");
    idle(2);

    // R6: bit reversal
    d = {32'h80C0E0F1, 32'h12345678, 32'h00FF0102, 32'h7F3C99A5};
    for (int i = 0; i < VW/8; i++) e[i*8 +: 8] = rev8(d[i*8 +: 8]);
    drive(d, {LANES{REVRS}}, 8'h00, e, "R6 reverse");
    idle(1);

    // R8: zero matrix yields constant everywhere
    drive({4{$urandom}}, '0, 8'hA7, {(VW/8){8'hA7}}, "R8 zero matrix");
    // R8: identity plus constant added to every byte
    d = {4{32'h0F1E2D3C}};
    for (int i = 0; i < VW/8; i++) e[i*8 +: 8] = d[i*8 +: 8] ^ 8'h5C;
    drive(d, {LANES{IDENT}}, 8'h5C, e, "R8 constant add");
    idle(1);

    // R7: lane independence, lane0 identity and lane1 reversal on the same bytes
    d = {2{64'hC3A5_1F80_0172_E4D9}};
    e[63:0] = d[63:0];
    for (int i = 8; i < 16; i++) e[i*8 +: 8] = rev8(d[i*8 +: 8]);
    drive(d, {REVRS, IDENT}, 8'h00, e, "R7 lane independence");
    idle(2);

    // R4: random matrices and constants, back-to-back strobes
    for (int t = 0; t < 40; t++) begin
      logic [7:0] b;
      d = {$urandom, $urandom, $urandom, $urandom};
      m = {$urandom, $urandom, $urandom, $urandom};
      b = 8'($urandom);
      drive(d, m, b, ref_model(d, m, b), "R4 random");
      if (t % 7 == 0) idle(1 + t % 3);
    end
    // R4: single-row matrix, row 0 -> result bit 7 is parity of data
    d = {4{32'h00070103}};
    m = {LANES{64'h00000000000000FF}};
    drive(d, m, 8'h00, ref_model(d, m, 8'h00), "R4 row0 parity");
    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule